// File: doc/BRIEF.md
# Timeslot Pattern Checker

The checker watches a time-division multiplexed byte stream. It keeps only the one byte per 125 µs frame whose link index and timeslot index match two configuration selectors. That byte is checked in one of two modes. In static mode it is compared with a programmable reference byte. In sequence mode it is treated as eight consecutive bits of an 11-stage pseudo-random sequence, and the checker locks onto that sequence by itself.

A rising edge on the enable input starts a measurement. While the checker is locked, a frame counter advances on each frame-sync pulse. An error counter collects the number of mismatched bits. The lock state, both counters and the most recent static byte are presented as outputs so that a register bridge can read them.

Top module: `ts_pattern_chk`

## Requirements
- R1: A received byte is checked only when `byte_vld_i` is high, `byte_link_i` equals `cfg_link_i` and `byte_slot_i` equals `cfg_slot_i`, and the checker is running. All other bytes change no output.
- R2: Static mode (`cfg_seq_mode_i`=0) compares the selected byte with `cfg_ref_i`. On a match, `locked_o` is set. On a mismatch, `locked_o` is cleared and `err_cnt_o` grows by the number of differing bits.
- R3: In static mode, `last_byte_o` takes each selected byte. In sequence mode, `last_byte_o` keeps its value.
- R4: Sequence mode (`cfg_seq_mode_i`=1) checks the sequence b[n] = b[n-9] XOR b[n-11]. Each byte carries eight consecutive bits, with bit 7 first.
- R5: In sequence mode, the first 11 bits after a (re)start seed the reference. Lock is declared after 16 further bits that match the reference with no error in between. After 24 correct bits the checker is not locked; after 32 correct bits it is locked. An error during verification restarts seeding.
- R6: In sequence mode, each mismatched bit adds one to `err_cnt_o`, but only while locked. Bits seen during seeding or verification add nothing.
- R7: While locked, lock is lost when the 8th error falls within a 64-bit window that starts at lock. Seeding then restarts, and a following correct stream locks again.
- R8: `frame_cnt_o` increments on a `fsync_i` pulse when the checker is running, enabled and locked. Otherwise it does not change.
- R9: Both counters are CNT_W bits wide and stop at all-ones.
- R10: A rising edge of `cfg_en_i` clears both counters and the lock state, and starts the checker.
- R11: After `cfg_en_i` falls, selected bytes are still checked up to the next `fsync_i` pulse. From that pulse on, nothing is checked and the counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Receive enable; a rising edge starts a run |
| cfg_seq_mode_i | input | 1 | 0 = static byte, 1 = PRBS-11 |
| cfg_link_i | input | LINK_W | Selected link index |
| cfg_slot_i | input | SLOT_W | Selected timeslot index |
| cfg_ref_i | input | 8 | Reference byte for static mode |
| fsync_i | input | 1 | Frame-sync pulse, once per 125 µs frame |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_link_i | input | LINK_W | Link index of the received byte |
| byte_slot_i | input | SLOT_W | Timeslot index of the received byte |
| byte_data_i | input | 8 | Received byte |
| locked_o | output | 1 | Pattern or sequence locked |
| last_byte_o | output | 8 | Last selected byte received in static mode |
| frame_cnt_o | output | CNT_W | Frames counted while locked |
| err_cnt_o | output | CNT_W | Bit errors counted |

## Verification
The selection logic is swept over every configured link and timeslot pair, against bytes sent on every pair. The error count must then show exactly one mismatched byte, which separates a correct selector from one that ignores either the link or the slot. In static mode, matching, single-bit and fully inverted bytes separate the lock decision from the bit-weighted error count. In sequence mode, a clean bench-generated PRBS-11 stream fixes the lock point between 24 and 32 bits. A single flipped bit must be counted while lock holds, and an inverted byte must drop lock. Saturation, the stop-at-next-frame behaviour and the clear on restart are each driven to their limit with a narrow counter.

// File: rtl/ts_chk_pkg.sv
package ts_chk_pkg;
  typedef enum logic [1:0] {
    SYNC_SEED   = 2'd0,
    SYNC_VERIFY = 2'd1,
    SYNC_LOCK   = 2'd2
  } sync_st_e;

  function automatic logic [3:0] pop8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/ts_slot_pick.sv
module ts_slot_pick #(
  parameter int LINK_W = 6,
  parameter int SLOT_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [LINK_W-1:0] cfg_link_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic              vld_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        data_i,
  output logic              vld_o,
  output logic [7:0]        data_o
);
  logic hit;
  assign hit = vld_i && run_i && (link_i == cfg_link_i) && (slot_i == cfg_slot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= hit && !clr_i;
      if (hit) data_o <= data_i;
    end
  end

  // R1: a picked byte always came from a strobed byte on the selected link
  assert_pick_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ($past(vld_i) && $past(link_i) == $past(cfg_link_i)
               && $past(slot_i) == $past(cfg_slot_i)));
endmodule

// File: rtl/ts_prbs_sync.sv
module ts_prbs_sync
  import ts_chk_pkg::*;
#(
  parameter int LFSR_LEN    = 11,
  parameter int TAP_A       = 9,
  parameter int VERIFY_BITS = 16,
  parameter int WIN_BITS    = 64,
  parameter int WIN_ERR_MAX = 8,
  localparam int CNT_BW     = $clog2(WIN_BITS + 1),
  localparam int WERR_BW    = $clog2(WIN_ERR_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       locked_o,
  output logic [3:0] err_bits_o
);
  sync_st_e              st_q, st_d;
  logic [LFSR_LEN-1:0]   hist_q, hist_d;
  logic [CNT_BW-1:0]     cnt_q, cnt_d;
  logic [WERR_BW-1:0]    werr_q, werr_d;
  logic [3:0]            err_d;

  always_comb begin
    logic b, p;
    st_d   = st_q;
    hist_d = hist_q;
    cnt_d  = cnt_q;
    werr_d = werr_q;
    err_d  = '0;
    if (vld_i) begin
      for (int i = 7; i >= 0; i--) begin
        b = byte_i[i];
        p = hist_d[TAP_A-1] ^ hist_d[LFSR_LEN-1];
        unique case (st_d)
          SYNC_SEED: begin
            hist_d = {hist_d[LFSR_LEN-2:0], b};
            cnt_d  = cnt_d + 1'b1;
            if (cnt_d == CNT_BW'(LFSR_LEN)) begin
              st_d  = SYNC_VERIFY;
              cnt_d = '0;
            end
          end
          SYNC_VERIFY: begin
            if (b == p) begin
              hist_d = {hist_d[LFSR_LEN-2:0], p};
              cnt_d  = cnt_d + 1'b1;
              if (cnt_d == CNT_BW'(VERIFY_BITS)) begin
                st_d   = SYNC_LOCK;
                cnt_d  = '0;
                werr_d = '0;
              end
            end else begin
              st_d  = SYNC_SEED;
              cnt_d = '0;
            end
          end
          default: begin
            hist_d = {hist_d[LFSR_LEN-2:0], p};
            cnt_d  = cnt_d + 1'b1;
            if (b != p) begin
              err_d  = err_d + 1'b1;
              werr_d = werr_d + 1'b1;
            end
            if (werr_d == WERR_BW'(WIN_ERR_MAX)) begin
              st_d   = SYNC_SEED;
              cnt_d  = '0;
              werr_d = '0;
            end else if (cnt_d == CNT_BW'(WIN_BITS)) begin
              cnt_d  = '0;
              werr_d = '0;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SYNC_SEED;
      hist_q <= '0;
      cnt_q  <= '0;
      werr_q <= '0;
    end else if (clr_i) begin
      st_q   <= SYNC_SEED;
      hist_q <= '0;
      cnt_q  <= '0;
      werr_q <= '0;
    end else begin
      st_q   <= st_d;
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      werr_q <= werr_d;
    end
  end

  assign locked_o   = (st_q == SYNC_LOCK);
  assign err_bits_o = clr_i ? 4'd0 : err_d;

  // R5: lock is only reached from the verification phase
  assert_lock_via_verify_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(st_q) == SYNC_VERIFY);
  // R6: errors are reported only from the locked state
  assert_err_when_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_bits_o != 4'd0) |-> locked_o);
  // R7: window error count stays below the drop threshold
  assert_window_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    werr_q < WERR_BW'(WIN_ERR_MAX));
endmodule

// File: rtl/ts_sat_cnt.sv
module ts_sat_cnt #(
  parameter int W     = 32,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     q_o
);
  logic [W:0] sum;
  assign sum = {1'b0, q_o} + (W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (sum[W]) q_o <= '1;
    else             q_o <= sum[W-1:0];
  end

  // R9: once at all-ones the counter holds until cleared
  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == '1 && !clr_i) |=> q_o == '1);
  // R9: without a clear the counter never goes down
  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> q_o >= $past(q_o));
endmodule

// File: rtl/ts_pattern_chk.sv
module ts_pattern_chk
  import ts_chk_pkg::*;
#(
  parameter int NUM_LINKS   = 60,
  parameter int NUM_SLOTS   = 512,
  parameter int CNT_W       = 32,
  parameter int VERIFY_BITS = 16,
  parameter int WIN_BITS    = 64,
  parameter int WIN_ERR_MAX = 8,
  localparam int LINK_W     = $clog2(NUM_LINKS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_seq_mode_i,
  input  logic [LINK_W-1:0] cfg_link_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [7:0]        cfg_ref_i,
  input  logic              fsync_i,
  input  logic              byte_vld_i,
  input  logic [LINK_W-1:0] byte_link_i,
  input  logic [SLOT_W-1:0] byte_slot_i,
  input  logic [7:0]        byte_data_i,
  output logic              locked_o,
  output logic [7:0]        last_byte_o,
  output logic [CNT_W-1:0]  frame_cnt_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic       en_q, run_q, start, st_lock_q;
  logic       sel_vld;
  logic [7:0] sel_data;
  logic       trk_lock;
  logic [3:0] trk_err, err_inc;
  logic [0:0] frame_inc;

  assign start = cfg_en_i && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      en_q <= cfg_en_i;
      if (start)                      run_q <= 1'b1;
      else if (fsync_i && !cfg_en_i)  run_q <= 1'b0;
    end
  end

  ts_slot_pick #(.LINK_W(LINK_W), .SLOT_W(SLOT_W)) u_pick (
    .clk_i, .rst_ni,
    .clr_i      (start),
    .run_i      (run_q),
    .cfg_link_i, .cfg_slot_i,
    .vld_i      (byte_vld_i),
    .link_i     (byte_link_i),
    .slot_i     (byte_slot_i),
    .data_i     (byte_data_i),
    .vld_o      (sel_vld),
    .data_o     (sel_data)
  );

  ts_prbs_sync #(
    .VERIFY_BITS(VERIFY_BITS), .WIN_BITS(WIN_BITS), .WIN_ERR_MAX(WIN_ERR_MAX)
  ) u_sync (
    .clk_i, .rst_ni,
    .clr_i      (start),
    .vld_i      (sel_vld && cfg_seq_mode_i),
    .byte_i     (sel_data),
    .locked_o   (trk_lock),
    .err_bits_o (trk_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_lock_q   <= 1'b0;
      last_byte_o <= '0;
    end else if (start) begin
      st_lock_q <= 1'b0;
    end else if (sel_vld && !cfg_seq_mode_i) begin
      st_lock_q   <= (sel_data == cfg_ref_i);
      last_byte_o <= sel_data;
    end
  end

  assign locked_o = cfg_seq_mode_i ? trk_lock : st_lock_q;

  always_comb begin
    if (start)                             err_inc = '0;
    else if (cfg_seq_mode_i)               err_inc = trk_err;
    else if (sel_vld)                      err_inc = pop8(sel_data ^ cfg_ref_i);
    else                                   err_inc = '0;
  end

  assign frame_inc = (fsync_i && run_q && cfg_en_i && locked_o && !start) ? 1'b1 : 1'b0;

  ts_sat_cnt #(.W(CNT_W), .INC_W(4)) u_err_cnt (
    .clk_i, .rst_ni, .clr_i(start), .inc_i(err_inc), .q_o(err_cnt_o)
  );

  ts_sat_cnt #(.W(CNT_W), .INC_W(1)) u_frame_cnt (
    .clk_i, .rst_ni, .clr_i(start), .inc_i(frame_inc), .q_o(frame_cnt_o)
  );

  // R10: a start leaves counters and lock cleared
  assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (err_cnt_o == '0 && frame_cnt_o == '0 && !st_lock_q));
  // R3: static capture register holds while sequence mode is selected
  assert_last_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_seq_mode_i) |-> $stable(last_byte_o));
  // R8: frames advance only while locked
  assert_frame_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_o != $past(frame_cnt_o)) |-> ($past(locked_o) || $past(start)));
  // R11: a stopped checker with nothing in flight holds its counters
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !sel_vld && !start) |=> ($stable(err_cnt_o) && $stable(frame_cnt_o)));
endmodule

// File: tb/sim_ts_pattern_chk.sv
module sim_ts_pattern_chk;
  localparam int NL = 4, NS = 8, CW = 8;
  localparam int LW = 2, SW = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          en = 0, mode = 0, fs = 0, bv = 0;
  logic [LW-1:0] cl = '0, bl = '0;
  logic [SW-1:0] cs = '0, bs = '0;
  logic [7:0]    ref_b = '0, bd = '0;
  logic          lk;
  logic [7:0]    lb;
  logic [CW-1:0] fc, ec;
  int            n_chk = 0, n_bad = 0;
  logic          seq [0:255];

  always #5 clk = ~clk;

  ts_pattern_chk #(.NUM_LINKS(NL), .NUM_SLOTS(NS), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_seq_mode_i(mode),
    .cfg_link_i(cl), .cfg_slot_i(cs), .cfg_ref_i(ref_b), .fsync_i(fs),
    .byte_vld_i(bv), .byte_link_i(bl), .byte_slot_i(bs), .byte_data_i(bd),
    .locked_o(lk), .last_byte_o(lb), .frame_cnt_o(fc), .err_cnt_o(ec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int l, input int s, input logic [7:0] d);
    bv = 1; bl = LW'(l); bs = SW'(s); bd = d;
    tick();
    bv = 0;
    tick(2);
  endtask

  task automatic restart();
    en = 0; tick();
    en = 1; tick(2);
  endtask

  task automatic pulse_fs();
    fs = 1; tick();
    fs = 0; tick();
  endtask

  function automatic logic [7:0] seq_byte(input int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = seq[8*k+i];
    return v;
  endfunction

  initial begin
    int ts;
    ts = 0;
    while (ts < 200000) begin
      @(posedge clk); ts++;
    end
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", ts);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] sd;
    sd = 11'b101_1001_1101;
    for (int i = 0; i < 11; i++) seq[i] = sd[10-i];
    for (int n = 11; n < 256; n++) seq[n] = seq[n-9] ^ seq[n-11];

    tick(3);
    chk(!lk && fc == 0 && ec == 0 && lb == 0, "reset", int'(ec), 0);
    rst_n = 1; tick(2);

    // static mode
    mode = 0; ref_b = 8'hA5; cl = 1; cs = 3;
    restart();
    send(1, 3, 8'hA5);
    chk(lk == 1, "R2 match lock", int'(lk), 1);
    chk(ec == 0, "R2 match err", int'(ec), 0);
    chk(lb == 8'hA5, "R3 capture", int'(lb), 8'hA5);
    pulse_fs();
    chk(fc == 1, "R8 locked frame", int'(fc), 1);
    send(1, 3, 8'hA4);
    chk(ec == 1 && !lk, "R2 one bit", int'(ec), 1);
    chk(lb == 8'hA4, "R3 capture mismatch", int'(lb), 8'hA4);
    pulse_fs();
    chk(fc == 1, "R8 unlocked frame", int'(fc), 1);
    send(1, 3, 8'h5A);
    chk(ec == 9, "R2 eight bits", int'(ec), 9);
    restart();
    chk(ec == 0 && fc == 0 && !lk, "R10 clear", int'(ec), 0);

    // R1 exhaustive selector sweep: 0x00 vs 0xA5 differs in 4 bits
    for (int c = 0; c < NL * NS; c++) begin
      cl = LW'(c / NS); cs = SW'(c % NS);
      restart();
      for (int t = 0; t < NL * NS; t++) send(t / NS, t % NS, 8'h00);
      chk(ec == 4, "R1 sweep", int'(ec), 4);
    end

    // R11 stop at next frame
    cl = 1; cs = 3;
    restart();
    en = 0;
    send(1, 3, 8'h00);
    chk(ec == 4, "R11 still checking", int'(ec), 4);
    pulse_fs();
    send(1, 3, 8'h00);
    chk(ec == 4, "R11 stopped", int'(ec), 4);
    en = 1; tick(2);
    chk(ec == 0, "R10 reenable clear", int'(ec), 0);

    // R9 saturation
    ref_b = 8'h00;
    for (int i = 0; i < 33; i++) send(1, 3, 8'hFF);
    chk(ec == 8'hFF, "R9 err sat", int'(ec), 255);
    send(1, 3, 8'h00);
    for (int i = 0; i < 260; i++) pulse_fs();
    chk(fc == 8'hFF, "R9 frame sat", int'(fc), 255);
    chk(lb == 8'h00, "R3 static last", int'(lb), 0);

    // sequence mode
    mode = 1;
    restart();
    pulse_fs();
    chk(fc == 0, "R8 no frame before lock", int'(fc), 0);
    for (int k = 0; k < 3; k++) send(1, 3, seq_byte(k));
    chk(!lk, "R5 not locked at 24", int'(lk), 0);
    send(1, 3, seq_byte(3));
    chk(lk, "R5 R4 locked at 32", int'(lk), 1);
    chk(ec == 0, "R6 clean stream", int'(ec), 0);
    chk(lb == 8'h00, "R3 held in sequence", int'(lb), 0);
    for (int i = 0; i < 3; i++) pulse_fs();
    chk(fc == 3, "R8 seq frames", int'(fc), 3);
    send(1, 3, seq_byte(4));
    send(1, 3, seq_byte(5));
    send(1, 3, seq_byte(6) ^ 8'h80);
    chk(ec == 1 && lk, "R6 one bit error", int'(ec), 1);
    send(1, 3, ~seq_byte(7));
    chk(!lk, "R7 drop", int'(lk), 0);
    chk(ec == 8, "R7 errors to drop", int'(ec), 8);
    for (int k = 8; k < 20; k++) send(1, 3, seq_byte(k));
    chk(lk, "R7 relock", int'(lk), 1);
    chk(ec == 8, "R6 no count while unlocked", int'(ec), 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule